// File: doc/BRIEF.md
# Sticky Code-Fetch Disable Register

This block holds a two-bit field that decides whether the processor may fetch instructions out of flash memory. The field only takes effect while the read-protection-active input is high. When protection is off, fetching is always permitted. The block emits a single permission output, and the stored field can be read back unchanged.

Software updates the field through a write port, which has a write enable and two data bits. During startup, in test mode, or while protection is off, any value may be written. Under active protection outside those modes, a write is accepted only if it keeps fetching disabled. The only way back to the enabled state is the application reset.

Two encodings are illegal. Either one behaves like the disabled code. Once the field holds an illegal code, it ignores every write until the application reset. A write that the rules forbid is dropped silently, and the field keeps its previous value.

Top module: `code_fetch_lock`

## Requirements
- R1: While `app_rst_n` is low, `field_q` is 2'b10 (fetch enabled) and `fetch_ok` is 1. After release, this value holds until a write is accepted.
- R2: While `prot_active` is 0, `fetch_ok` is 1 whatever `field_q` holds.
- R3: While `prot_active` is 1, `fetch_ok` is 1 only when `field_q` is 2'b10. For 2'b01, 2'b00 and 2'b11 it is 0.
- R4: When `field_q` holds a legal code (2'b10 or 2'b01) and either `boot_or_test` is 1 or `prot_active` is 0, a write takes effect. Such a write loads any value of `wr_data` into `field_q` at the next clock edge.
- R5: When `prot_active` is 1 and `boot_or_test` is 0, a write of 2'b10 is ignored and `field_q` keeps its value.
- R6: When `prot_active` is 1, `boot_or_test` is 0 and `field_q` holds a legal code, a write of 2'b01, 2'b00 or 2'b11 is loaded at the next clock edge.
- R7: While `field_q` holds 2'b00 or 2'b11, every write is ignored in every mode until the application reset.
- R8: `field_q` shows the stored code exactly, including the illegal codes.
- R9: With `wr_en` low, `field_q` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| app_rst_n | input | 1 | Application reset, active low, asynchronous by default |
| wr_en | input | 1 | Write strobe for the field |
| wr_data | input | 2 | Value to write |
| boot_or_test | input | 1 | High during startup or test mode; permits unrestricted writes |
| prot_active | input | 1 | Read protection currently active |
| fetch_ok | output | 1 | Instruction fetch from flash permitted |
| field_q | output | 2 | Stored field, read back as held |

## Verification
The checker evaluates a set of properties on every clock:

- protection off always permits fetch;
- under protection, any code other than enabled blocks fetch;
- an illegal code never changes;
- under protection outside startup or test mode, the field never moves back to enabled;
- with no write, the field holds;
- a disabling write under protection is loaded exactly.

Only the bench scenarios can show the value loaded by reset. They also show that a write of the enabled code is dropped under protection, that startup or test mode reopens a disabled field, and that an illegal code stays locked even in the permissive modes until a reset clears it.

// File: rtl/code_fetch_lock_pkg.sv
package code_fetch_lock_pkg;

   typedef enum logic [1:0] {
      CLS_ON  = 2'd0,
      CLS_OFF = 2'd1,
      CLS_BAD = 2'd2
   } fetch_class_e;

endpackage

// File: rtl/code_fetch_lock_classify.sv
module code_fetch_lock_classify
   import code_fetch_lock_pkg::*;
#(
   parameter int unsigned CODE_W   = 2,
   parameter logic [CODE_W-1:0] ON_CODE  = 2'b10,
   parameter logic [CODE_W-1:0] OFF_CODE = 2'b01
) (
   input  logic [CODE_W-1:0] code_i,
   output fetch_class_e      cls_o
);

   always_comb begin
      if (code_i == ON_CODE)       cls_o = CLS_ON;
      else if (code_i == OFF_CODE) cls_o = CLS_OFF;
      else                         cls_o = CLS_BAD;
   end

endmodule

// File: rtl/code_fetch_lock_policy.sv
module code_fetch_lock_policy
   import code_fetch_lock_pkg::*;
#(
   parameter int unsigned CODE_W  = 2,
   parameter logic [CODE_W-1:0] ON_CODE = 2'b10
) (
   input  fetch_class_e      cur_cls_i,
   input  logic              wr_en_i,
   input  logic [CODE_W-1:0] wr_data_i,
   input  logic              boot_or_test_i,
   input  logic              prot_active_i,
   output logic              take_o
);

   logic free_mode;
   logic disabling;

   always_comb begin
      free_mode = boot_or_test_i | ~prot_active_i;
      disabling = (wr_data_i != ON_CODE);
      take_o    = wr_en_i & (cur_cls_i != CLS_BAD) & (free_mode | disabling);
   end

endmodule

// File: rtl/code_fetch_lock_store.sv
module code_fetch_lock_store #(
   parameter int unsigned CODE_W    = 2,
   parameter logic [CODE_W-1:0] RST_CODE = 2'b10,
   parameter bit          ASYNC_RST = 1'b1
) (
   input  logic              clk,
   input  logic              app_rst_n,
   input  logic              load_i,
   input  logic [CODE_W-1:0] data_i,
   output logic [CODE_W-1:0] q_o
);

   generate
      if (ASYNC_RST) begin : g_async
         always_ff @(posedge clk or negedge app_rst_n) begin
            if (!app_rst_n)  q_o <= RST_CODE;
            else if (load_i) q_o <= data_i;
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (!app_rst_n)  q_o <= RST_CODE;
            else if (load_i) q_o <= data_i;
         end
      end
   endgenerate

endmodule

// File: rtl/code_fetch_lock.sv
module code_fetch_lock
   import code_fetch_lock_pkg::*;
#(
   parameter int unsigned CODE_W    = 2,
   parameter logic [CODE_W-1:0] ON_CODE  = 2'b10,
   parameter logic [CODE_W-1:0] OFF_CODE = 2'b01,
   parameter bit          ASYNC_RST = 1'b1
) (
   input  logic              clk,
   input  logic              app_rst_n,
   input  logic              wr_en,
   input  logic [CODE_W-1:0] wr_data,
   input  logic              boot_or_test,
   input  logic              prot_active,
   output logic              fetch_ok,
   output logic [CODE_W-1:0] field_q
);

   localparam int unsigned NUM_CODES = 1 << CODE_W;

   initial begin
      if (CODE_W < 2)
         $error("code_fetch_lock: CODE_W must be at least 2");
      if (ON_CODE == OFF_CODE)
         $error("code_fetch_lock: enable and disable codes must differ");
      if (NUM_CODES < 3)
         $error("code_fetch_lock: need room for an illegal code");
   end

   fetch_class_e cur_cls;
   logic         take;

   code_fetch_lock_classify #(
      .CODE_W(CODE_W), .ON_CODE(ON_CODE), .OFF_CODE(OFF_CODE)
   ) u_classify (
      .code_i (field_q),
      .cls_o  (cur_cls)
   );

   code_fetch_lock_policy #(
      .CODE_W(CODE_W), .ON_CODE(ON_CODE)
   ) u_policy (
      .cur_cls_i      (cur_cls),
      .wr_en_i        (wr_en),
      .wr_data_i      (wr_data),
      .boot_or_test_i (boot_or_test),
      .prot_active_i  (prot_active),
      .take_o         (take)
   );

   code_fetch_lock_store #(
      .CODE_W(CODE_W), .RST_CODE(ON_CODE), .ASYNC_RST(ASYNC_RST)
   ) u_store (
      .clk       (clk),
      .app_rst_n (app_rst_n),
      .load_i    (take),
      .data_i    (wr_data),
      .q_o       (field_q)
   );

   assign fetch_ok = ~prot_active | (cur_cls == CLS_ON);

endmodule

// File: rtl/code_fetch_lock_chk.sv
module code_fetch_lock_chk #(
   parameter int unsigned CODE_W    = 2,
   parameter logic [CODE_W-1:0] ON_CODE  = 2'b10,
   parameter logic [CODE_W-1:0] OFF_CODE = 2'b01
) (
   input logic              clk,
   input logic              app_rst_n,
   input logic              wr_en,
   input logic [CODE_W-1:0] wr_data,
   input logic              boot_or_test,
   input logic              prot_active,
   input logic              fetch_ok,
   input logic [CODE_W-1:0] field_q
);

   logic bad_code;
   logic locked_mode;
   assign bad_code    = (field_q != ON_CODE) && (field_q != OFF_CODE);
   assign locked_mode = prot_active && !boot_or_test;

   // R2
   a_r2_unprot_fetch: assert property (@(posedge clk) disable iff (!app_rst_n)
      !prot_active |-> fetch_ok);

   // R3
   a_r3_prot_blocks: assert property (@(posedge clk) disable iff (!app_rst_n)
      (prot_active && field_q != ON_CODE) |-> !fetch_ok);

   // R7
   a_r7_bad_sticks: assert property (@(posedge clk) disable iff (!app_rst_n)
      bad_code |=> $stable(field_q));

   // R5
   a_r5_no_reenable: assert property (@(posedge clk) disable iff (!app_rst_n)
      (locked_mode && field_q != ON_CODE) |=> field_q != ON_CODE);

   // R6
   a_r6_disable_loads: assert property (@(posedge clk) disable iff (!app_rst_n)
      (wr_en && locked_mode && !bad_code && wr_data != ON_CODE)
      |=> field_q == $past(wr_data));

   // R9
   a_r9_idle_holds: assert property (@(posedge clk) disable iff (!app_rst_n)
      !wr_en |=> $stable(field_q));

endmodule

bind code_fetch_lock code_fetch_lock_chk #(
   .CODE_W(CODE_W), .ON_CODE(ON_CODE), .OFF_CODE(OFF_CODE)
) i_chk (
   .clk          (clk),
   .app_rst_n    (app_rst_n),
   .wr_en        (wr_en),
   .wr_data      (wr_data),
   .boot_or_test (boot_or_test),
   .prot_active  (prot_active),
   .fetch_ok     (fetch_ok),
   .field_q      (field_q)
);

// File: tb/test_code_fetch_lock.sv
`timescale 1ns/1ps
module test_code_fetch_lock;

   logic       clk = 1'b0;
   logic       app_rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_data = 2'b00;
   logic       boot_or_test = 1'b0;
   logic       prot_active = 1'b0;
   logic       fetch_ok;
   logic [1:0] field_q;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [1:0] exp_field_q[$];
   logic       exp_ok_q[$];
   string      exp_tag_q[$];
   logic [1:0] model = 2'b10;

   always #2.5 clk = ~clk;

   code_fetch_lock i_code_fetch_lock (
      .clk          (clk),
      .app_rst_n    (app_rst_n),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .boot_or_test (boot_or_test),
      .prot_active  (prot_active),
      .fetch_ok     (fetch_ok),
      .field_q      (field_q)
   );

   // driver: applies one cycle of stimulus and queues the expected result
   task automatic step(input logic rst_n, input logic we, input logic [1:0] d,
                       input logic bt, input logic prot, input string tag);
      logic legal;
      @(negedge clk);
      app_rst_n    = rst_n;
      wr_en        = we;
      wr_data      = d;
      boot_or_test = bt;
      prot_active  = prot;
      legal = (model == 2'b10) || (model == 2'b01);
      if (!rst_n)
         model = 2'b10;
      else if (we && legal && (bt || !prot || d != 2'b10))
         model = d;
      exp_field_q.push_back(model);
      exp_ok_q.push_back(!prot || model == 2'b10);
      exp_tag_q.push_back(tag);
   endtask

   // monitor: compares after each active edge
   always @(posedge clk) begin
      #1;
      if (exp_field_q.size() > 0) begin
         logic [1:0] ef;
         logic       eo;
         string      t;
         ef = exp_field_q.pop_front();
         eo = exp_ok_q.pop_front();
         t  = exp_tag_q.pop_front();
         checks += 2;
         if (field_q !== ef) begin
            errors++;
            $display("FAIL %s field_q actual %b expected %b", t, field_q, ef);
         end
         if (fetch_ok !== eo) begin
            errors++;
            $display("FAIL %s fetch_ok actual %b expected %b", t, fetch_ok, eo);
         end
      end
   end

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // reset state
      step(0, 0, 2'b00, 0, 0, "R1 reset");
      step(0, 1, 2'b01, 0, 1, "R1 reset under write");
      step(1, 0, 2'b00, 0, 1, "R1 hold after release");
      // unprotected: free writes, fetch always allowed
      step(1, 1, 2'b01, 0, 0, "R4 R2 unprotected disable");
      step(1, 0, 2'b01, 0, 1, "R3 protected off code blocks");
      step(1, 1, 2'b10, 0, 1, "R5 reenable ignored");
      step(1, 1, 2'b10, 1, 1, "R4 boot mode reenable");
      step(1, 1, 2'b01, 0, 1, "R6 protected disable");
      step(1, 0, 2'b10, 0, 1, "R9 no strobe holds");
      step(1, 1, 2'b00, 0, 1, "R6 R8 protected to illegal 00");
      step(1, 1, 2'b10, 1, 1, "R7 boot write ignored");
      step(1, 1, 2'b10, 0, 0, "R7 R2 unprotected write ignored");
      step(1, 1, 2'b01, 0, 1, "R7 protected write ignored");
      step(0, 0, 2'b00, 0, 1, "R1 reset clears lock");
      step(1, 1, 2'b11, 0, 1, "R6 R8 protected to illegal 11");
      step(1, 0, 2'b11, 0, 1, "R3 illegal 11 blocks");
      step(1, 1, 2'b01, 1, 0, "R7 illegal 11 sticks");
      step(0, 0, 2'b00, 0, 0, "R1 second reset");
      step(1, 1, 2'b11, 0, 0, "R4 R8 free write illegal");
      step(1, 0, 2'b00, 0, 0, "R2 illegal unprotected allows");
      step(0, 0, 2'b00, 0, 0, "R1 third reset");
      step(1, 1, 2'b01, 1, 1, "R4 boot write disable");
      step(1, 1, 2'b10, 0, 0, "R4 unprotected reenable");
      step(1, 0, 2'b00, 0, 1, "R3 protected enabled fetch");
      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule